// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block is the clock master and serializer of a stereo audio link. It takes one left and one right parallel sample at a time through a valid/ready handshake. It produces a bit clock, a word-select line and a single data line that carries both channels one after the other. Within each channel slot of fixed length, the sample is sent MSB first, and is placed in one of three alignments chosen by a mode input:
- delayed by one bit clock after the word-select edge (I2S),
- starting right at the edge (left-justified),
- ending on the last bit clock of the slot (right-justified).

The number of significant bits per sample is programmable, and every unused bit position is sent as zero. A pair is taken from a one-entry holding register at the start of each frame. When no new pair has arrived, the previous pair is sent again. The data and word-select lines change only on the falling bit-clock edge, so a receiver can sample them on the rising edge.

Top module: `aud_tx`

## Requirements
- R1: While rst_ni is low, bclk_o is 0, ws_o is 1, sd_o is 0 and ready_o is 1.
- R2: bclk_o has a period of 2*HALF_DIV clk_i cycles at 50% duty cycle. ws_o and sd_o change only on the clk_i edge where bclk_o falls.
- R3: A frame lasts 2*SLOT_W bit clocks. ws_o is 0 for the first SLOT_W bit clocks (left channel) and 1 for the next SLOT_W bit clocks (right channel).
- R4: With mode_i 2'b01 or 2'b11 (left-justified), sample bit wlen-1 is sent on the first bit clock of its slot. The following bits go out MSB first, down to bit 0, and the rest of the slot is 0.
- R5: With mode_i 2'b00 (I2S), the line carries the left-justified stream delayed by one bit clock, with word select not delayed. The MSB is on the second bit clock of the slot. The first bit clock of the slot carries bit 0 of the preceding slot's sample when that slot's word length equals SLOT_W, and 0 otherwise.
- R6: With mode_i 2'b10 (right-justified), sample bit 0 is sent on the last bit clock of the slot, preceded MSB first by the other significant bits. The leading bit clocks of the slot are 0.
- R7: Only sample bits below the word length are sent. A wlen_i value above SAMPLE_W acts as SAMPLE_W, and a wlen_i of 0 gives an all-zero slot.
- R8: ready_o is 1 while the holding register is empty. A cycle with valid_i and ready_o both high fills the register and drops ready_o. ready_o rises again on the edge where the frame starts and ws_o falls.
- R9: When no pair has been accepted since the previous frame start, the next frame repeats the previous pair.
- R10: mode_i and wlen_i are sampled at the frame start and apply to the whole frame. A change in the middle of a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| left_i | input | SAMPLE_W | Left sample; significant bits right-aligned |
| right_i | input | SAMPLE_W | Right sample; significant bits right-aligned |
| valid_i | input | 1 | Sample pair present |
| ready_o | output | 1 | Holding register empty |
| mode_i | input | 2 | 00 I2S, 01/11 left-justified, 10 right-justified |
| wlen_i | input | clog2(SAMPLE_W+1) | Significant bits per sample |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 left, 1 right |
| sd_o | output | 1 | Serial data |

## Verification
A wrong frame-position counter or a wrongly loaded pair shows up within one frame. It appears as a misplaced word-select edge or as a data bit that differs from the expected stream at a fixed position in the slot. A broken I2S delay element shows up only on the first bit clock of a slot, and only when the previous word filled its slot, so the stimulus includes back-to-back full-width I2S words whose last bit is 1. Handshake faults show up on ready_o within a few clk_i cycles of an accept or of the next frame start.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S   = 2'b00,
    FMT_LEFT  = 2'b01,
    FMT_RIGHT = 2'b10,
    FMT_LEFT2 = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_tx_bclk_gen.sv
`timescale 1ns/1ps
module aud_tx_bclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bclk_o,
  output logic fall_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             bclk_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_W'(HALF_DIV - 1));
  assign fall_o = wrap & bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) bclk_q <= ~bclk_q;
    end
  end
endmodule

// File: rtl/aud_tx_stage.sv
`timescale 1ns/1ps
module aud_tx_stage #(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                take_i,
  output logic                ready_o,
  output logic                full_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  logic full_q;
  logic accept;

  assign ready_o = ~full_q;
  assign full_o  = full_q;
  assign accept  = valid_i & ~full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      full_q <= accept | (full_q & ~take_i);
      if (accept) begin
        left_o  <= left_i;
        right_o <= right_i;
      end
    end
  end
endmodule

// File: rtl/aud_tx_shifter.sv
`timescale 1ns/1ps
module aud_tx_shifter
  import aud_tx_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 32,
  parameter int WL_W     = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                stage_full_i,
  input  logic [SAMPLE_W-1:0] stage_left_i,
  input  logic [SAMPLE_W-1:0] stage_right_i,
  input  logic [1:0]          mode_i,
  input  logic [WL_W-1:0]     wlen_i,
  output logic                take_o,
  output logic                ws_o,
  output logic                sd_o
);
  localparam int FRAME = 2 * SLOT_W;
  localparam int POS_W = $clog2(FRAME);

  logic [POS_W-1:0]    pos_q, pos_n;
  logic [SAMPLE_W-1:0] act_l_q, act_r_q, left_n, right_n, smp_n;
  fmt_e                mode_q, mode_n;
  logic [WL_W-1:0]     wlen_q, wlen_n;
  logic                lj_prev_q, ws_q, sd_q;
  logic                at_end, load, slot_n, lj_bit, rj_bit, sd_n;
  int                  k_n, wl_n, k_q;

  function automatic logic [WL_W-1:0] clamp_wl(input logic [WL_W-1:0] w);
    return (int'(w) > SAMPLE_W) ? WL_W'(SAMPLE_W) : w;
  endfunction

  // bit idx of s if it is a significant bit, else 0
  function automatic logic pick(input logic [SAMPLE_W-1:0] s, input int idx, input int wl);
    logic b;
    b = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++)
      if (i == idx && i < wl) b = s[i];
    return b;
  endfunction

  assign at_end = (pos_q == POS_W'(FRAME - 1));
  assign load   = tick_i & at_end;
  assign take_o = load & stage_full_i;

  always_comb begin
    pos_n   = at_end ? '0 : pos_q + 1'b1;
    left_n  = take_o ? stage_left_i  : act_l_q;
    right_n = take_o ? stage_right_i : act_r_q;
    mode_n  = load ? fmt_e'(mode_i) : mode_q;
    wlen_n  = load ? clamp_wl(wlen_i) : wlen_q;
    slot_n  = (pos_n >= POS_W'(SLOT_W));
    k_n     = slot_n ? int'(pos_n) - SLOT_W : int'(pos_n);
    wl_n    = int'(wlen_n);
    smp_n   = slot_n ? right_n : left_n;
    lj_bit  = pick(smp_n, wl_n - 1 - k_n, wl_n);
    rj_bit  = pick(smp_n, SLOT_W - 1 - k_n, wl_n);
    case (mode_n)
      FMT_I2S:   sd_n = lj_prev_q;  // left-justified stream one bit clock late
      FMT_RIGHT: sd_n = rj_bit;
      default:   sd_n = lj_bit;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= POS_W'(FRAME - 1);
      act_l_q   <= '0;
      act_r_q   <= '0;
      mode_q    <= FMT_LEFT;
      wlen_q    <= WL_W'(SAMPLE_W);
      lj_prev_q <= 1'b0;
      ws_q      <= 1'b1;
      sd_q      <= 1'b0;
    end else if (tick_i) begin
      pos_q     <= pos_n;
      act_l_q   <= left_n;
      act_r_q   <= right_n;
      mode_q    <= mode_n;
      wlen_q    <= wlen_n;
      lj_prev_q <= lj_bit;
      ws_q      <= slot_n;
      sd_q      <= sd_n;
    end
  end

  assign ws_o = ws_q;
  assign sd_o = sd_q;
  assign k_q  = (pos_q >= POS_W'(SLOT_W)) ? int'(pos_q) - SLOT_W : int'(pos_q);

  assert_ws_at_slot_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_q) |-> (pos_q == '0 || pos_q == POS_W'(SLOT_W)));

  assert_rj_pad_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == FMT_RIGHT && (k_q + int'(wlen_q) < SLOT_W)) |-> !sd_q);

  assert_take_at_frame_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (pos_q == '0));
endmodule

// File: rtl/aud_tx.sv
`timescale 1ns/1ps
module aud_tx #(
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 32,
  parameter int HALF_DIV = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [SAMPLE_W-1:0]           left_i,
  input  logic [SAMPLE_W-1:0]           right_i,
  input  logic                          valid_i,
  output logic                          ready_o,
  input  logic [1:0]                    mode_i,
  input  logic [$clog2(SAMPLE_W+1)-1:0] wlen_i,
  output logic                          bclk_o,
  output logic                          ws_o,
  output logic                          sd_o
);
  localparam int WL_W = $clog2(SAMPLE_W + 1);

  logic                fall, take, full;
  logic [SAMPLE_W-1:0] stg_l, stg_r;

  aud_tx_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bclk_o(bclk_o),
    .fall_o(fall)
  );

  aud_tx_stage #(.SAMPLE_W(SAMPLE_W)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .left_i (left_i),
    .right_i(right_i),
    .take_i (take),
    .ready_o(ready_o),
    .full_o (full),
    .left_o (stg_l),
    .right_o(stg_r)
  );

  aud_tx_shifter #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .WL_W(WL_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (fall),
    .stage_full_i (full),
    .stage_left_i (stg_l),
    .stage_right_i(stg_r),
    .mode_i       (mode_i),
    .wlen_i       (wlen_i),
    .take_o       (take),
    .ws_o         (ws_o),
    .sd_o         (sd_o)
  );

  assert_change_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(ws_o) || !$stable(sd_o)) |-> $fell(bclk_o));

  assert_accept_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  assert_ready_at_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $fell(ws_o));
endmodule

// File: tb/aud_tx_tb_top.sv
`timescale 1ns/1ps
module aud_tx_tb_top;
  localparam int SLOT_W   = 32;
  localparam int SAMPLE_W = 32;
  localparam int HALF_DIV = 2;
  localparam int WL_W     = 6;
  localparam int FRAME    = 2 * SLOT_W;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [SAMPLE_W-1:0] left_i = '0, right_i = '0;
  logic                valid_i = 1'b0;
  logic [1:0]          mode_i = 2'b01;
  logic [WL_W-1:0]     wlen_i = 6'd24;
  logic                ready_o, bclk_o, ws_o, sd_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [31:0] l; logic [31:0] r; string tag; } item_t;
  item_t pq[$];
  item_t last_item;
  string rep_tag = "R9";

  always #5 clk = ~clk;

  aud_tx #(.SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .HALF_DIV(HALF_DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .left_i(left_i), .right_i(right_i),
    .valid_i(valid_i), .ready_o(ready_o), .mode_i(mode_i), .wlen_i(wlen_i),
    .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // expected left-justified bit at frame position p
  function automatic logic lj_at(input item_t it, input int wl, input int p);
    int k; logic [31:0] s;
    s = (p >= SLOT_W) ? it.r : it.l;
    k = (p >= SLOT_W) ? p - SLOT_W : p;
    if (k < wl) return s[wl - 1 - k];
    return 1'b0;
  endfunction

  function automatic logic rj_at(input item_t it, input int wl, input int p);
    int k; logic [31:0] s;
    s = (p >= SLOT_W) ? it.r : it.l;
    k = (p >= SLOT_W) ? p - SLOT_W : p;
    if (SLOT_W - 1 - k < wl) return s[SLOT_W - 1 - k];
    return 1'b0;
  endfunction

  // monitor / scoreboard
  initial begin
    logic [63:0] exp_sd, got_sd, got_ws;
    logic        prev_ws, prev_last, started;
    int          p, wl;
    item_t       cur;
    string       tag;
    prev_ws = 1'b1; prev_last = 1'b0; started = 1'b0; p = 0;
    exp_sd = '0; got_sd = '0; got_ws = '0;
    last_item.l = '0; last_item.r = '0; last_item.tag = "R4";
    cur = last_item; tag = "R4";
    wait (rst_ni);
    forever begin
      @(posedge bclk_o);
      if (!ws_o && prev_ws) begin
        if (started) chk(p == FRAME, "R3", "frame length", 64'(p), 64'(FRAME));
        if (pq.size() > 0) begin cur = pq.pop_front(); tag = cur.tag; end
        else begin cur = last_item; tag = rep_tag; end
        last_item = cur;
        wl = (int'(wlen_i) > SAMPLE_W) ? SAMPLE_W : int'(wlen_i);
        for (int i = 0; i < FRAME; i++) begin
          case (mode_i)
            2'b00:   exp_sd[i] = (i == 0) ? prev_last : lj_at(cur, wl, i - 1);
            2'b10:   exp_sd[i] = rj_at(cur, wl, i);
            default: exp_sd[i] = lj_at(cur, wl, i);
          endcase
        end
        prev_last = lj_at(cur, wl, FRAME - 1);
        p = 0; started = 1'b1;
      end
      if (started && p < FRAME) begin
        got_sd[p] = sd_o;
        got_ws[p] = ws_o;
        p++;
        if (p == FRAME) begin
          chk(got_sd == exp_sd, tag, "frame data", got_sd, exp_sd);
          chk(got_ws == 64'hFFFF_FFFF_0000_0000, "R3", "word select", got_ws,
              64'hFFFF_FFFF_0000_0000);
        end
      end
      prev_ws = ws_o;
    end
  end

  task automatic send(input logic [31:0] l, input logic [31:0] r, input logic [1:0] m,
                      input logic [WL_W-1:0] wl, input string tag);
    item_t it;
    @(negedge ws_o);
    repeat (8) @(negedge clk);
    chk(ready_o == 1'b1, "R8", "ready before accept", 64'(ready_o), 64'd1);
    left_i = l; right_i = r; mode_i = m; wlen_i = wl; valid_i = 1'b1;
    it.l = l; it.r = r; it.tag = tag;
    pq.push_back(it);
    @(negedge clk);
    valid_i = 1'b0;
    chk(ready_o == 1'b0, "R8", "ready after accept", 64'(ready_o), 64'd0);
    left_i = '1; right_i = '1;  // held register must not follow the inputs
  endtask

  task automatic idle(input string tag);
    @(negedge ws_o);
    rep_tag = tag;
  endtask

  task automatic cfg_change(input logic [1:0] m, input logic [WL_W-1:0] wl);
    @(negedge ws_o);
    repeat (8) @(negedge clk);
    mode_i = m; wlen_i = wl;
    rep_tag = "R10";
  endtask

  // bit clock period in clk cycles
  initial begin
    int n;
    logic prev;
    wait (rst_ni);
    @(posedge bclk_o);
    @(negedge clk);
    n = 0; prev = 1'b1;
    while (!(bclk_o && !prev)) begin
      prev = bclk_o;
      @(negedge clk);
      n++;
    end
    chk(n == 2 * HALF_DIV, "R2", "bclk period", 64'(n), 64'(2 * HALF_DIV));
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bclk_o == 1'b0, "R1", "bclk in reset", 64'(bclk_o), 64'd0);
    chk(ws_o == 1'b1, "R1", "ws in reset", 64'(ws_o), 64'd1);
    chk(sd_o == 1'b0, "R1", "sd in reset", 64'(sd_o), 64'd0);
    chk(ready_o == 1'b1, "R1", "ready in reset", 64'(ready_o), 64'd1);
    rst_ni = 1'b1;

    send(32'h00A5_C39E, 32'h0017_F00D, 2'b01, 6'd24, "R4");
    send(32'hDEAD_1234, 32'hBEEF_8001, 2'b01, 6'd16, "R7");
    send(32'h0081_7E42, 32'h00C0_FFEE, 2'b00, 6'd24, "R5");
    send(32'h9ABC_DEF1, 32'h8765_4321, 2'b00, 6'd32, "R5");
    send(32'hF0E1_D2C3, 32'h1357_9BDF, 2'b00, 6'd32, "R5");
    send(32'h0055_AA33, 32'h00CC_3301, 2'b10, 6'd24, "R6");
    send(32'h1234_8421, 32'h5678_7FFF, 2'b10, 6'd16, "R6");
    idle("R9");
    cfg_change(2'b01, 6'd20);
    send(32'h00B4_D2E1, 32'h0069_1E87, 2'b11, 6'd24, "R4");
    send(32'hCAFE_BABE, 32'h0BAD_F00D, 2'b01, 6'd40, "R7");
    send(32'hFFFF_FFFF, 32'h8000_0001, 2'b01, 6'd0, "R7");
    rep_tag = "R9";
    repeat (3) @(negedge ws_o);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule